// File: doc/BRIEF.md
# Logic Self-Test Controller with 4-bit Pattern Generator

The block runs a self-test on a small combinational circuit. In normal operation it passes the system input bus straight through to the circuit under test, so the path adds no register stage. When `start` is pulsed, the controller hands the circuit's inputs to an internal 4-bit linear feedback shift register. This register walks through all fifteen non-zero states in one fixed order. While the run lasts, every response of the circuit is folded into a multiple-input signature register, so no response is stored.

After exactly fifteen patterns the controller compares the final signature with a golden value, which is a parameter. It raises `done` and reports the result on `pass`. Both outputs hold until the next accepted start. A start that arrives during a run is dropped. The circuit under test sits outside the top module, and a small parameterised stand-in for it is provided.

Top module: `lbist_top`

## Requirements
- R1: While `bistOn` is low, `cutIn` equals `sysIn` in the same cycle, with no register stage on the path.
- R2: A start sampled at a clock edge while idle makes `bistOn` high from that edge for exactly 15 cycles. Over those cycles `cutIn` takes 0001, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, written MSB first, one value per cycle.
- R3: The generator never holds 0000. A run presents 15 distinct non-zero patterns, and the next run starts again at 0001.
- R4: `done` goes high on the 15th clock edge after the edge that accepted the start. It stays high until the next accepted start, which clears it at that edge.
- R5: `start` sampled while `bistOn` is high has no effect. The pattern order, the timing of `done` and the value of `pass` are unchanged.
- R6: The signature begins at zero. At each clock edge of a run it updates as sig' = {sig[W-2:0],0} XOR (sig[W-1] ? POLY : 0) XOR cutOut. `pass` is 1 exactly when the value after the 15th update equals `GOLDEN`.
- R7: After reset, `done`, `pass` and `bistOn` are 0. `pass` is never 1 while `done` is 0.
- R8: A start accepted while `done` is high begins a fresh run. Its result depends only on the responses of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a self-test run |
| sysIn | input | 4 | Functional inputs for the circuit under test |
| cutOut | input | OUT_W | Response of the circuit under test |
| cutIn | output | 4 | Inputs driven into the circuit under test |
| bistOn | output | 1 | High while test patterns are applied |
| done | output | 1 | Run finished; result valid |
| pass | output | 1 | Signature matched the golden value |

## Verification
The assertions assume that `cutOut` is a pure combinational function of `cutIn`, settled before each rising edge. They also assume that `start` changes only away from the clock edge. The bench meets both conditions. It drives every input at the falling edge, and it forms `cutOut` from the stand-in circuit plus an optional single-cycle error mask that is also set at the falling edge. Random system inputs, random start pulses during runs and random fault positions are all drawn from one fixed seed, so every run of the bench is reproducible.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int LFSR_W = 4;
  localparam int PERIOD = (1 << LFSR_W) - 1;
  localparam logic [LFSR_W-1:0] SEED = 4'b0001;
  // right-shifting register: next = {^(state & TAPS), state[3:1]}
  localparam logic [LFSR_W-1:0] TAPS = 4'b0011;

  typedef struct packed {
    logic sel;      // route generator to circuit inputs
    logic seed;     // reload generator
    logic step;     // advance generator
    logic clear;    // zero signature and result
    logic capture;  // fold response into signature
    logic finish;   // latch comparison result
  } strobe_t;
endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr
  import lbist_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              seedLoad,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  logic [LFSR_W-1:0] nextState;

  always_comb begin
    fb = ^(state & TAPS);
    nextState = {fb, state[LFSR_W-1:1]};
    if (nextState == '0) nextState = SEED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else if (seedLoad) state <= SEED;
    else if (step) state <= nextState;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN) state != '0); // R3
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         capture,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig,
  output logic [W-1:0] sigNext
);
  always_comb begin
    sigNext = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0) ^ resp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sig <= '0;
    else if (clear) sig <= '0;
    else if (capture) sig <= sigNext;
  end

  AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rstN) clear |=> sig == '0); // R6
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t ctl,
  output logic    running,
  output logic    done
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic accept;
  logic lastCycle;

  always_comb begin
    accept = start && !running;
    lastCycle = running && (cnt == LAST);
    ctl.sel = running;
    ctl.seed = accept;
    ctl.clear = accept;
    ctl.step = running;
    ctl.capture = running;
    ctl.finish = lastCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt <= '0;
      done <= 1'b0;
    end else if (accept) begin
      running <= 1'b1;
      cnt <= '0;
      done <= 1'b0;
    end else if (lastCycle) begin
      running <= 1'b0;
      cnt <= '0;
      done <= 1'b1;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN) lastCycle |=> done && !running); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (running && start && !lastCycle) |=> running && $stable(done)); // R5
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN) (start && !running) |=> running && !done); // R8
endmodule

// File: rtl/lbist_datapath.sv
module lbist_datapath
  import lbist_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter logic [OUT_W-1:0] POLY = 8'h1D,
  parameter logic [OUT_W-1:0] GOLDEN = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [LFSR_W-1:0] sysIn,
  input  logic [OUT_W-1:0]  cutOut,
  output logic [LFSR_W-1:0] cutIn,
  output logic              pass
);
  logic [LFSR_W-1:0] pattern;
  logic [OUT_W-1:0] sig;
  logic [OUT_W-1:0] sigNext;

  lbist_lfsr uGen (
    .clk(clk), .rstN(rstN), .seedLoad(ctl.seed), .step(ctl.step), .state(pattern)
  );

  lbist_misr #(.W(OUT_W), .POLY(POLY)) uSig (
    .clk(clk), .rstN(rstN), .clear(ctl.clear), .capture(ctl.capture),
    .resp(cutOut), .sig(sig), .sigNext(sigNext)
  );

  always_comb cutIn = ctl.sel ? pattern : sysIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pass <= 1'b0;
    else if (ctl.clear) pass <= 1'b0;
    else if (ctl.finish) pass <= (sigNext == GOLDEN);
  end

  AST_SEED_AT_START: assert property (@(posedge clk) disable iff (!rstN) $rose(ctl.sel) |-> pattern == SEED); // R2
  AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rstN) (!ctl.finish && !ctl.clear) |=> $stable(pass)); // R6
endmodule

// File: rtl/lbist_cut_stub.sv
module lbist_cut_stub #(
  parameter int IN_W = 4,
  parameter logic [IN_W-1:0] ADD_K = 4'd5
) (
  input  logic [IN_W-1:0]   a,
  output logic [2*IN_W-1:0] y
);
  always_comb y = {a ^ {a[0], a[IN_W-1:1]}, a + ADD_K};
endmodule

// File: rtl/lbist_top.sv
module lbist_top
  import lbist_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter logic [OUT_W-1:0] POLY = 8'h1D,
  parameter logic [OUT_W-1:0] GOLDEN = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LFSR_W-1:0] sysIn,
  input  logic [OUT_W-1:0]  cutOut,
  output logic [LFSR_W-1:0] cutIn,
  output logic              bistOn,
  output logic              done,
  output logic              pass
);
  strobe_t ctl;

  lbist_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .running(bistOn), .done(done)
  );

  lbist_datapath #(.OUT_W(OUT_W), .POLY(POLY), .GOLDEN(GOLDEN)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sysIn(sysIn), .cutOut(cutOut),
    .cutIn(cutIn), .pass(pass)
  );

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN) !done |-> !pass); // R7
endmodule

// File: tb/sim_lbist_top.sv
module sim_lbist_top;
  localparam logic [3:0] SEQ [15] = '{4'b0001, 4'b1000, 4'b0100, 4'b0010, 4'b1001,
    4'b1100, 4'b0110, 4'b1011, 4'b0101, 4'b1010, 4'b1101, 4'b1110, 4'b1111, 4'b0111, 4'b0011};
  localparam logic [7:0] POLY = 8'h1D;

  function automatic logic [7:0] cutModel(input logic [3:0] a);
    logic [3:0] rot;
    rot = {a[0], a[3:1]};
    return {a ^ rot, a + 4'd5};
  endfunction

  function automatic logic [7:0] sigOf(input int fIdx, input logic [7:0] fMask);
    logic [7:0] s;
    logic [7:0] r;
    s = 8'h00;
    for (int k = 0; k < 15; k++) begin
      r = cutModel(SEQ[k]);
      if (k == fIdx) r = r ^ fMask;
      s = {s[6:0], 1'b0} ^ (s[7] ? POLY : 8'h00) ^ r;
    end
    return s;
  endfunction

  localparam logic [7:0] GOLD = sigOf(-1, 8'h00);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] sysIn = 4'h0;
  logic [7:0] inj = 8'h00;
  logic [7:0] stubOut;
  logic [7:0] cutOut;
  logic [3:0] cutIn;
  logic bistOn, done, pass;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lbist_cut_stub uStub (.a(cutIn), .y(stubOut));
  assign cutOut = stubOut ^ inj;

  lbist_top #(.OUT_W(8), .POLY(POLY), .GOLDEN(GOLD)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .sysIn(sysIn), .cutOut(cutOut),
    .cutIn(cutIn), .bistOn(bistOn), .done(done), .pass(pass)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one run; fIdx<0 means no fault, midStart>=0 pulses start at that pattern index
  task automatic runTest(input int fIdx, input logic [7:0] fMask, input int midStart);
    logic [15:0] seen;
    logic expPass;
    seen = '0;
    expPass = (sigOf(fIdx, fMask) == GOLD);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 15; k++) begin
      check(cutIn == SEQ[k], "R2 pattern", cutIn, SEQ[k]);
      check(bistOn && !done, "R4 busy", {bistOn, done}, 2'b10);
      check(cutIn != 4'h0 && !seen[cutIn], "R3 distinct nonzero", cutIn, 1);
      seen[cutIn] = 1'b1;
      inj = (k == fIdx) ? fMask : 8'h00;
      start = (k == midStart) ? 1'b1 : ($urandom_range(0, 3) == 0 && midStart >= 0);
      sysIn = 4'($urandom);
      if (k < 14) @(negedge clk);
    end
    @(negedge clk);
    inj = 8'h00;
    start = 1'b0;
    check(done && !bistOn, "R4 done after 15", {done, bistOn}, 2'b10);
    check(pass == expPass, "R6 verdict", pass, expPass);
    if (midStart >= 0) check(done && pass == expPass, "R5 mid-run start ignored", pass, expPass);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check(!done && !pass && !bistOn, "R7 reset", {done, pass, bistOn}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sysIn = 4'($urandom);
      #1 check(cutIn == sysIn, "R1 passthrough", cutIn, sysIn);
      check(!pass && !done, "R7 idle", {pass, done}, 0);
    end
    runTest(-1, 8'h00, -1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) sysIn = 4'($urandom);
      #1 check(cutIn == sysIn && !bistOn, "R1 passthrough after run", cutIn, sysIn);
      check(done && pass, "R4 held until start", {done, pass}, 2'b11);
    end
    runTest(0, 8'h01, -1);
    runTest(-1, 8'h00, 4);
    runTest(14, 8'h80, 9);
    runTest(-1, 8'h00, -1);
    check(pass, "R8 fresh run after fail", pass, 1);
    for (int r = 0; r < 6; r++) begin
      int f;
      f = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 14)) : -1;
      runTest(f, 8'(1 << $urandom_range(0, 7)), int'($urandom_range(0, 20)) - 3);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule